// File: doc/BRIEF.md
# Serial Channel Select Controller

This block is the digital control core of a serially programmed eight-way switch array. A host shifts a four-bit command into it over a serial data line. Each bit is taken on a rising serial clock edge while an active-high select line is held high. The command carries one enable bit and a three-bit switch code. When the select line falls, the block applies the new command to eight one-hot switch-enable outputs. It first forces a gap with every enable low, so that the old switch is always off before the new one closes.

The shift register also drives a serial output, delayed by four shifts, so several controllers can share one data stream. In such a chain the last four bits shifted in before the select line falls are the ones each controller keeps. The serial output has its own output-enable, which is low while the controller is deselected. Serial clock, select and data are sampled with two-flop synchronizers on the system clock, and the block detects their edges internally. The serial clock may run at no more than a quarter of the system clock rate.

Top module: `serialChanSelect`

## Requirements
- R1: While the select line is high, each rising serial clock edge shifts the serial data bit into a four-bit shift register. The first bit of a frame is the enable bit, followed by code bits 2, 1 and 0 in that order.
- R2: When the captured enable bit is 1, code value n (0 to 7) drives switch enable bit n high and all other enables low.
- R3: When the captured enable bit is 0, all eight enables are low whatever the code bits are.
- R4: The serial output shows the bit that was shifted in four shifts earlier. In a chain of frames, only the last four bits shifted before the select line falls form the command.
- R5: The old enable drops OFF_DLY system clock cycles after the falling select edge is detected. Counting edges from a select change made between clock edges, the enables are low after edge 3+OFF_DLY.
- R6: The new enable pattern appears after edge 3+ON_DLY. Between the drop and that edge, all enables are low, so two enables are never high in the same cycle.
- R7: The applied enables do not change while a new frame is being shifted in. They change only after the next falling select edge.
- R8: The serial output-enable is high while the synchronized select is high. It is low from the second clock edge after the select line falls.
- R9: Serial clock edges that arrive while the select line is low have no effect, and the shift register keeps its contents.
- R10: Reset clears the shift register, drives all enables low and deasserts the serial output-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock, sampled |
| csIn | input | 1 | Active-high frame select, sampled |
| sdIn | input | 1 | Serial data in |
| sdOut | output | 1 | Serial data out, high impedance when deselected |
| sdOutEn | output | 1 | Output-enable for sdOut |
| swEn | output | NUM_SW | One-hot switch enables |

## Verification
Every input passes through two synchronizer flops, and the select falling edge is seen one edge later. As a result, a select drop made between edges captures the command at edge 3. The old enables clear at edge 3+OFF_DLY and the new pattern appears at edge 3+ON_DLY.

The bench drives inputs on falling clock edges and samples outputs on the falling edge after each rising edge k. It compares every cycle of the break-before-make window against this schedule, so an early or late transition of even one cycle is reported. A serial shift completes at the third system edge after a serial clock rise. The bench holds each serial clock phase for four system cycles and checks the serial output only once the phase has ended.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef struct packed {
    logic shift;
    logic capture;
    logic clear;
    logic apply;
    logic outEn;
  } scsStrobe_t;
endpackage

// File: rtl/scsControl.sv
module scsControl
  import scs_pkg::*;
#(
  parameter int ON_DLY  = 6,
  parameter int OFF_DLY = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       csIn,
  output scsStrobe_t ctl
);
  localparam int CNT_W = $clog2(ON_DLY + 1);

  logic [1:0] sclkSync, csSync;
  logic       sclkPrev, csPrev;
  logic       busy;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[0], sclkIn};
      csSync   <= {csSync[0], csIn};
      sclkPrev <= sclkSync[1];
      csPrev   <= csSync[1];
    end
  end

  logic sclkRise, csFall;
  assign sclkRise = sclkSync[1] & ~sclkPrev;
  assign csFall   = ~csSync[1] & csPrev;

  // break-before-make sequencer: cnt counts cycles since the captured fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (csFall) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(1);
    end else if (busy) begin
      if (cnt == CNT_W'(ON_DLY)) busy <= 1'b0;
      else                       cnt  <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    ctl.shift   = sclkRise & csSync[1];
    ctl.capture = csFall;
    ctl.clear   = busy & (cnt == CNT_W'(OFF_DLY));
    ctl.apply   = busy & (cnt == CNT_W'(ON_DLY));
    ctl.outEn   = csSync[1];
  end

  // R6: the clear strobe always precedes apply within one sequence
  p_clear_before_apply_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.apply |-> !ctl.clear);
  // R1: shifting only happens inside a selected frame
  p_shift_in_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |-> ctl.outEn);
endmodule

// File: rtl/scsDatapath.sv
module scsDatapath
  import scs_pkg::*;
#(
  parameter int NUM_SW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdIn,
  input  scsStrobe_t        ctl,
  output logic [NUM_SW-1:0] swEn,
  output logic              sdBit
);
  localparam int SEL_W   = $clog2(NUM_SW);
  localparam int FRAME_W = SEL_W + 1;

  logic [1:0]         sdSync;
  logic [FRAME_W-1:0] shiftReg, cmdReg;
  logic [NUM_SW-1:0]  decoded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdSync   <= '0;
      shiftReg <= '0;
      cmdReg   <= '0;
      swEn     <= '0;
    end else begin
      sdSync <= {sdSync[0], sdIn};
      if (ctl.shift)   shiftReg <= {shiftReg[FRAME_W-2:0], sdSync[1]};
      if (ctl.capture) cmdReg   <= shiftReg;
      if (ctl.apply)        swEn <= decoded;
      else if (ctl.clear)   swEn <= '0;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NUM_SW; i++) begin : g_dec
      assign decoded[i] = cmdReg[FRAME_W-1] && (cmdReg[SEL_W-1:0] == SEL_W'(i));
    end
  endgenerate

  assign sdBit = shiftReg[FRAME_W-1];

  // R2: never more than one switch enabled
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(swEn));
  // R6: no direct hand-over from one active switch to another
  p_bbm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (swEn != '0 && $past(swEn) != '0) |-> swEn == $past(swEn));
  // R9: deselected register keeps its contents
  p_hold_deselected_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.outEn |=> $stable(shiftReg));
endmodule

// File: rtl/serialChanSelect.sv
module serialChanSelect
  import scs_pkg::*;
#(
  parameter int NUM_SW  = 8,
  parameter int ON_DLY  = 6,
  parameter int OFF_DLY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csIn,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOutEn,
  output logic [NUM_SW-1:0] swEn
);
  scsStrobe_t ctl;
  logic       sdBit;

  scsControl #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u_ctl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csIn(csIn), .ctl(ctl));

  scsDatapath #(.NUM_SW(NUM_SW)) u_dp (
    .clk(clk), .rstN(rstN), .sdIn(sdIn), .ctl(ctl), .swEn(swEn), .sdBit(sdBit));

  assign sdOutEn = ctl.outEn;
  assign sdOut   = ctl.outEn ? sdBit : 1'bz;

  // R6: a new pattern is only loaded onto an all-off output
  p_gap_before_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.apply |-> swEn == '0);
  // R7: enables only move while a post-fall sequence runs
  p_hold_in_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |=> $stable(swEn));
endmodule

// File: tb/sim_serialChanSelect.sv
`timescale 1ns/1ps
module sim_serialChanSelect;
  localparam int NUM_SW = 8, ON_DLY = 6, OFF_DLY = 1;
  localparam int OFF_T = 3 + OFF_DLY, ON_T = 3 + ON_DLY;

  logic clk = 0, rstN = 0, sclkIn = 0, csIn = 0, sdIn = 0;
  logic sdOut, sdOutEn;
  logic [NUM_SW-1:0] swEn;

  int testCnt = 0, failCnt = 0;
  logic [3:0] model = '0;
  logic [NUM_SW-1:0] curEn = '0;

  serialChanSelect #(.NUM_SW(NUM_SW), .ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csIn(csIn), .sdIn(sdIn),
    .sdOut(sdOut), .sdOutEn(sdOutEn), .swEn(swEn));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NUM_SW-1:0] decodeCmd(input logic [3:0] c);
    return c[3] ? (NUM_SW'(1) << c[2:0]) : '0;
  endfunction

  task automatic raiseCs();
    csIn = 1; waitN(4);
    chk(sdOutEn === 1'b1, "R8 outEn high", sdOutEn, 1);
  endtask

  // shift n bits (MSB of bits first), checking serial out and held enables
  task automatic sendBits(input logic [7:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdIn = bits[i]; waitN(2);
      sclkIn = 1; waitN(4);
      sclkIn = 0; waitN(2);
      model = {model[2:0], bits[i]};
      chk(sdOut === model[3], "R1/R4 serial out", sdOut, model[3]);
      chk(swEn === curEn, "R7 enables held in frame", swEn, curEn);
    end
  endtask

  // drop select and check every cycle of the break-before-make window
  task automatic dropCs(input logic [NUM_SW-1:0] newEn, input string tag);
    logic [NUM_SW-1:0] exp;
    csIn = 0;
    for (int k = 1; k <= ON_T + 2; k++) begin
      @(posedge clk); @(negedge clk);
      exp = (k < OFF_T) ? curEn : (k < ON_T) ? '0 : newEn;
      chk(swEn === exp, tag, swEn, exp);
      if (k >= 2) chk(sdOutEn === 1'b0, "R8 outEn low", sdOutEn, 0);
    end
    curEn = newEn;
  endtask

  task automatic t_reset();
    chk(swEn === '0, "R10 enables after reset", swEn, 0);
    chk(sdOutEn === 1'b0, "R10 outEn after reset", sdOutEn, 0);
  endtask

  task automatic t_select(input logic [3:0] cmd, input string tag);
    raiseCs();
    sendBits({4'b0, cmd}, 4);
    dropCs(decodeCmd(cmd), tag);
  endtask

  task automatic t_chain();
    raiseCs();
    sendBits(8'b1110_1011, 8);  // R4: first frame passes through, second kept
    dropCs(decodeCmd(4'b1011), "R4 chain last frame sw3");
  endtask

  task automatic t_ignore();
    sdIn = 0;
    for (int i = 0; i < 4; i++) begin
      sclkIn = 1; waitN(4); sclkIn = 0; waitN(4);
    end
    chk(swEn === curEn, "R9 enables unchanged", swEn, curEn);
    raiseCs();
    chk(sdOut === model[3], "R9 register kept", sdOut, model[3]);
    dropCs(decodeCmd(model), "R9 same command reapplied");
  endtask

  initial begin
    #(200000 * 20);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    waitN(3); rstN = 1; waitN(2);
    t_reset();
    t_select(4'b1101, "R2/R5/R6 select sw5");
    t_select(4'b1000, "R2/R5/R6 select sw0");
    t_select(4'b1111, "R2/R5/R6 select sw7");
    t_select(4'b0111, "R3 enable bit low");
    t_select(4'b1010, "R2/R6 from all off sw2");
    t_chain();
    t_ignore();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule